// File: doc/BRIEF.md
# SPI Receive Shifter with Completion Flag

This block lets an 8-bit processor pull a stream of bytes from a memory card over an SPI link in mode 0. The processor sees three registers on a small memory-mapped bus: a data register holding the last received byte, a flag register with a completion bit, and a control register. The control register sets the active-low card select, picks a slow or a fast serial clock, enables automatic restart, and enables the interrupt. The engine runs eight clock pulses with MOSI held high, assembles the incoming bits most-significant first, and raises the completion flag. It then stops and waits until the processor collects the byte.

The slow rate is used while the card is being brought up, at a few hundred kHz. The fast rate toggles SCLK on every system clock, so one bit takes two system cycles. With automatic restart enabled, reading the data register clears the flag and launches the next byte in the same cycle. A poll-and-read loop can therefore stream a card's output with no extra bus writes.

Top module: `spi_rx_engine`

## Requirements
- R1: After reset, SCLK is low, card select (active low) is high, MOSI is high, the interrupt is low, and the flag and control registers (addresses 1 and 2) read 0.
- R2: In fast mode (control bit 1 = 1), SCLK changes level on every system clock during a burst. In slow mode, each SCLK half period lasts SLOW_HALF system clocks. The completion flag becomes visible 16 half periods after the clock edge that accepts the start.
- R3: SCLK idles low and MISO is sampled on each rising SCLK edge. Exactly eight rising edges occur per burst. The data register (address 0) returns the eight sampled bits with the first one in bit 7.
- R4: Completion sets bit 2 of the flag register (address 1). The interrupt output is high exactly while that bit is set and control bit 3 is set.
- R5: Once a byte is complete, no further SCLK edges occur until the data register is read. A write to the data register while the flag is set does not start a burst.
- R6: Reading the data register clears the flag. Writing the flag register with bit 2 set clears it. A write with bit 2 clear leaves it unchanged.
- R7: With auto-restart (control bit 2) set, a read of the data register while idle starts the next burst. With it clear, such a read starts nothing, and a write to the data register with the flag clear starts a burst.
- R8: A start request that arrives during a burst is ignored. The burst keeps its eight edges and its completion time.
- R9: MOSI is high at every rising SCLK edge.
- R10: Card select is driven low exactly while control bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (a data read has side effects) |
| bus_addr | input | 2 | Register address: 0 data, 1 flag, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt: flag AND enable |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the card, held high |
| spi_miso | input | 1 | Serial data from the card |
| spi_cs_n | output | 1 | Card select, active low |

## Verification
The bench builds the engine with SLOW_HALF set to 3 instead of its default of 125, which keeps slow-mode bursts at 48 cycles. Both rates can then be timed to the exact cycle within the same run. At this setting the half-period counter still runs through several counts, so an off-by-one in the divider shows up as a shifted flag edge. BITS and BUS_W stay at 8, so the flag bit position and the byte framing the card model produces match the register map.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  // register addresses on the CPU side
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_FLAG = 2'd1,
    ADDR_CTRL = 2'd2
  } reg_addr_e;

  // position of the completion bit in the flag register
  localparam int unsigned DONE_BIT = 2;

  // control fields, sel in bit 0 up to irq_en in bit 3
  typedef struct packed {
    logic irq_en;
    logic auto_go;
    logic fast;
    logic sel;
  } ctrl_t;

  // system clocks per SCLK half period
  function automatic int unsigned half_period(input logic fast, input int unsigned slow_half);
    return fast ? 1 : slow_half;
  endfunction

  // system clocks from accepted start to visible completion flag
  function automatic int unsigned burst_len(input logic fast, input int unsigned slow_half,
                                            input int unsigned nbits);
    return 2 * nbits * half_period(fast, slow_half);
  endfunction

endpackage

// File: rtl/spi_rx_tick.sv
module spi_rx_tick
  import spi_rx_pkg::*;
#(
  parameter int unsigned SLOW_HALF = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int unsigned CW = $clog2(SLOW_HALF) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = CW'(half_period(fast, SLOW_HALF));
  assign tick = run && (cnt >= lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // the counter never idles away from zero
  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            sclk,
  output logic [BITS-1:0] data,
  output logic            done
);
  localparam int unsigned BCW = (BITS > 2) ? $clog2(BITS) : 1;

  logic [BCW-1:0] bitcnt;
  logic           last;

  assign last = (bitcnt == BCW'(BITS - 1));
  assign done = busy && tick && sclk && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      bitcnt <= '0;
      data   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        sclk   <= 1'b0;
        bitcnt <= '0;
      end
    end else if (tick) begin
      if (!sclk) begin
        sclk <= 1'b1;
        data <= {data[BITS-2:0], miso};
      end else begin
        sclk <= 1'b0;
        if (last) begin
          busy <= 1'b0;
        end else begin
          bitcnt <= bitcnt + BCW'(1);
        end
      end
    end
  end

  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitcnt <= BCW'(BITS - 1)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !tick) |=> ($stable(bitcnt) && $stable(sclk) && busy));

endmodule

// File: rtl/spi_rx_regs.sv
module spi_rx_regs
  import spi_rx_pkg::*;
#(
  parameter int unsigned BITS  = 8,
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [BITS-1:0]  rx_data,
  input  logic             done,
  output ctrl_t            ctrl,
  output logic             flag,
  output logic             start,
  output logic             irq
);
  localparam logic [BUS_W-1:0] DONE_MASK = BUS_W'(1) << DONE_BIT;

  logic [BUS_W-1:0] ctrl_q;
  logic             rd_data, wr_data, wr_flag, wr_ctrl, flag_clr;
  reg_addr_e        addr;

  assign addr     = reg_addr_e'(bus_addr);
  assign rd_data  = bus_sel && bus_rd && (addr == ADDR_DATA);
  assign wr_data  = bus_sel && bus_wr && (addr == ADDR_DATA);
  assign wr_flag  = bus_sel && bus_wr && (addr == ADDR_FLAG);
  assign wr_ctrl  = bus_sel && bus_wr && (addr == ADDR_CTRL);
  assign flag_clr = rd_data || (wr_flag && |(bus_wdata & DONE_MASK));

  assign ctrl  = ctrl_t'(ctrl_q[3:0]);
  assign irq   = flag && ctrl.irq_en;
  assign start = (rd_data && ctrl.auto_go) || (wr_data && !flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (done) begin
        flag <= 1'b1;
      end else if (flag_clr) begin
        flag <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr)
      ADDR_DATA: bus_rdata = BUS_W'(rx_data);
      ADDR_FLAG: bus_rdata = flag ? DONE_MASK : '0;
      ADDR_CTRL: bus_rdata = ctrl_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !flag);

endmodule

// File: rtl/spi_rx_engine.sv
module spi_rx_engine
  import spi_rx_pkg::*;
#(
  parameter int unsigned BITS      = 8,
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned SLOW_HALF = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  ctrl_t           ctrl;
  logic            flag, start, busy, tick, done;
  logic [BITS-1:0] rx_data;

  spi_rx_regs #(.BITS(BITS), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .done(done),
    .ctrl(ctrl), .flag(flag), .start(start), .irq(irq)
  );

  spi_rx_tick #(.SLOW_HALF(SLOW_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .fast(ctrl.fast), .tick(tick)
  );

  spi_rx_shift #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .miso(spi_miso),
    .busy(busy), .sclk(spi_sclk), .data(rx_data), .done(done)
  );

  assign spi_mosi = 1'b1;
  assign spi_cs_n = ~ctrl.sel;

  // a pending byte freezes the serial clock
  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> !spi_sclk);

  // the flag never coexists with a running burst
  assert_flag_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> !busy);

endmodule

// File: tb/test_spi_rx_engine.sv
module test_spi_rx_engine;
  localparam int unsigned SLOW = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0;
  int fails = 0;

  // card model: shifts out on falling SCLK, MSB first
  logic [7:0] card_sh = 8'hFF;
  logic [7:0] card_next = 8'hFF;
  int fall_cnt = 0;
  int rise_cnt = 0;
  int mosi_bad = 0;

  assign spi_miso = card_sh[7];

  always #5 clk = ~clk;

  spi_rx_engine #(.SLOW_HALF(SLOW)) i_spi_rx_engine (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always @(negedge spi_sclk) begin
    if (rst_n) begin
      card_sh = {card_sh[6:0], 1'b0};
      fall_cnt = fall_cnt + 1;
      if (fall_cnt == 8) begin
        card_sh = card_next;
        fall_cnt = 0;
      end
    end
  end

  always @(posedge spi_sclk) begin
    if (rst_n) begin
      rise_cnt = rise_cnt + 1;
      if (spi_mosi !== 1'b1) mosi_bad = mosi_bad + 1;
    end
  end

  // stimulus table: {fast, byte}
  localparam logic [8:0] VEC [0:5] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h00}, {1'b0, 8'hFF},
    {1'b1, 8'h80}, {1'b0, 8'h01}, {1'b1, 8'h3C}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic load_card(input logic [7:0] b, input logic [7:0] nxt);
    card_sh = b;
    card_next = nxt;
    fall_cnt = 0;
    rise_cnt = 0;
  endtask

  // waits from the return of the starting access and checks the flag edge
  task automatic wait_done(input int unsigned t, input string tag);
    repeat (t - 1) @(negedge clk);
    chk({tag, " irq still low one cycle before completion"}, irq, 1'b0);
    @(negedge clk);
    chk({tag, " irq rises at completion"}, irq, 1'b1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sclk low", spi_sclk, 1'b0);
    chk("R1 cs_n high", spi_cs_n, 1'b1);
    chk("R1 mosi high", spi_mosi, 1'b1);
    chk("R1 irq low", irq, 1'b0);
    bus_read(2'd1, rd); chk("R1 flag reg", rd, 8'h00);
    bus_read(2'd2, rd); chk("R1 ctrl reg", rd, 8'h00);

    // table walk: R2 timing, R3 data order, R4 flag bit
    for (int i = 0; i < 6; i++) begin
      logic fast;
      int unsigned t;
      fast = VEC[i][8];
      t = 16 * (fast ? 1 : SLOW);
      bus_write(2'd2, {4'b0, 1'b1, 1'b0, fast, 1'b1});
      load_card(VEC[i][7:0], 8'hFF);
      bus_write(2'd0, 8'h00);
      wait_done(t, "R2");
      chk("R3 eight rising edges", rise_cnt, 8);
      bus_read(2'd1, rd); chk("R4 flag bit 2", rd, 8'h04);
      bus_read(2'd0, rd); chk("R3 byte MSB first", rd, {24'd0, VEC[i][7:0]});
      chk("R6 irq low after data read", irq, 1'b0);
    end

    // R10 card select follows control bit 0
    chk("R10 cs_n low with select set", spi_cs_n, 1'b0);
    bus_write(2'd2, 8'h0A);
    chk("R10 cs_n high with select clear", spi_cs_n, 1'b1);

    // R5 halt after completion, write ignored while flag set
    load_card(8'h96, 8'hFF);
    bus_write(2'd0, 8'h00);
    wait_done(16, "R5");
    repeat (20) @(negedge clk);
    chk("R5 no edges while pending", rise_cnt, 8);
    bus_write(2'd0, 8'h00);
    repeat (20) @(negedge clk);
    chk("R5 data write ignored while pending", rise_cnt, 8);
    chk("R5 sclk held low", spi_sclk, 1'b0);

    // R4 interrupt enable gating
    bus_write(2'd2, 8'h02);
    chk("R4 irq masked", irq, 1'b0);
    bus_write(2'd2, 8'h0A);
    chk("R4 irq unmasked", irq, 1'b1);

    // R6 flag clear by write
    bus_write(2'd1, 8'hFB);
    bus_read(2'd1, rd); chk("R6 write without bit 2 keeps flag", rd, 8'h04);
    bus_write(2'd1, 8'h04);
    bus_read(2'd1, rd); chk("R6 write bit 2 clears flag", rd, 8'h00);
    bus_read(2'd0, rd); chk("R6 data kept after clear", rd, 8'h96);

    // R7 auto restart streams two bytes
    bus_write(2'd2, 8'h0E);
    load_card(8'h5A, 8'hC3);
    bus_write(2'd0, 8'h00);
    wait_done(16, "R7");
    bus_read(2'd0, rd); chk("R7 first streamed byte", rd, 8'h5A);
    wait_done(16, "R7 restart");
    bus_read(2'd0, rd); chk("R7 second streamed byte", rd, 8'hC3);
    chk("R7 sixteen edges across two bytes", rise_cnt, 16);
    repeat (20) @(negedge clk);
    chk("R7 third burst launched by read", rise_cnt, 24);

    // R7 auto disabled: read starts nothing
    bus_write(2'd2, 8'h0A);
    repeat (40) @(negedge clk);
    bus_read(2'd0, rd);
    load_card(8'h11, 8'hFF);
    repeat (40) @(negedge clk);
    chk("R7 read without auto starts nothing", rise_cnt, 0);

    // R8 start during a slow burst is ignored
    bus_write(2'd2, 8'h09);
    load_card(8'h6D, 8'hFF);
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h00);
    repeat (16 * SLOW - 3) @(negedge clk);
    chk("R8 irq low before original completion", irq, 1'b0);
    @(negedge clk);
    chk("R8 completion at original time", irq, 1'b1);
    chk("R8 eight edges only", rise_cnt, 8);
    bus_read(2'd0, rd); chk("R8 byte intact", rd, 8'h6D);

    // R9 mosi seen high at every rising edge
    chk("R9 mosi high at all rising edges", mosi_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule